// File: doc/BRIEF.md
# Shadow-Buffered Pulse-Width Modulator

This block drives one pulse-width modulated output pin from a free-running counter. Software sets it up through four word-sized registers on a plain write port, and reads them back on a combinational read port: the live counter, the period, the duty length and a control word. The period and duty are counted in input clock cycles. Each period begins with the duty portion and ends with the inactive portion, so the output is left-aligned.

Period, duty and the two polarity bits are not applied as soon as they are written. They sit in written-value registers and are copied into the running set only when the counter wraps. A lock bit in the control word stops that copy. Software sets the lock, writes the new values, then clears the lock, and the whole set takes effect together at the first wrap after the unlock. When the channel starts from the disabled state, the written values are taken over at once and counting starts from zero.

Top module: `pwm_shadow_unit`

## Requirements
- R1: After reset every register reads 0 and the output is low.
- R2: Byte offsets 0x4, 0x8 and 0xC hold the period, the duty and the control word; each reads back the last full value written. Offset 0x0 is read-only and returns the counter. Other offsets read 0.
- R3: While running, the counter read at 0x0 goes 0, 1, ..., period−1 and wraps to 0. The first cycle after the enabling write shows 0.
- R4: While running, the output is at the duty level while the count is below the duty, and at the idle level otherwise. Control bit 3 set makes the duty level high. Control bit 4 set makes the idle level high.
- R5: A duty of 0 gives a constant idle level. A duty equal to or greater than a nonzero period gives a constant duty level. A period of 0 holds the output at the idle level with the counter at 0.
- R6: The channel runs only when control bits 0 and 1 are both set. Otherwise, from the cycle after the control write, the output sits at the level of control bit 4 and the counter reads 0.
- R7: While control bit 6 (lock) is set, new period, duty and polarity writes leave the running waveform unchanged.
- R8: After the lock is cleared, period, duty and polarity all switch together at the first counter wrap after the unlock write, never in the middle of a period.
- R9: With the lock clear and the channel running, period, duty and polarity writes still wait for the next counter wrap.
- R10: When the channel is enabled from the disabled state, the values written beforehand apply from the first cycle, with the count starting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one count per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Byte offset of the write |
| wr_data_i | input | DW | Write data |
| rd_addr_i | input | 4 | Byte offset of the read |
| rd_data_o | output | DW | Read data for rd_addr_i, same cycle |
| pwm_o | output | 1 | Modulated output |

## Verification
The hardest case to reach is a staged update landing exactly on a wrap. The unlock write, or the last write of an unlocked sequence, has to fall a chosen number of cycles before a period boundary so that the commit edge can be predicted. The bench schedules every write by its cycle index from the enabling edge. It computes the commit point as the first multiple of the old period after the unlock. It then predicts count and level from that point onward, and checks with lock and unlock placed at several phases of the period, with the lock never released, and with unlocked writes placed so that no wrap falls between them. A sweep over small periods, duties and all four polarity pairs covers the compare corners.

// File: rtl/pwm_shadow_pkg.sv
`timescale 1ns/1ps
package pwm_shadow_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_PER  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_DUTY = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'hC;

  localparam int CB_EN   = 0;
  localparam int CB_CONT = 1;
  localparam int CB_DHI  = 3;
  localparam int CB_IHI  = 4;
  localparam int CB_LOCK = 6;

  typedef struct packed {
    logic duty_hi;
    logic idle_hi;
  } pwm_pol_t;
endpackage

// File: rtl/pwm_rst_sync.sv
`timescale 1ns/1ps
module pwm_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/pwm_regbank.sv
`timescale 1ns/1ps
module pwm_regbank
  import pwm_shadow_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DW-1:0]     cnt_i,
  output logic [DW-1:0]     per_o,
  output logic [DW-1:0]     duty_o,
  output pwm_pol_t          pol_o,
  output logic              run_o,
  output logic              lock_o,
  output logic [DW-1:0]     rd_data_o
);
  logic [DW-1:0] per_q, per_d;
  logic [DW-1:0] duty_q, duty_d;
  logic [DW-1:0] ctrl_q, ctrl_d;
  logic          we_per, we_duty, we_ctrl;

  assign we_per  = wr_en_i && (wr_addr_i == OFS_PER);
  assign we_duty = wr_en_i && (wr_addr_i == OFS_DUTY);
  assign we_ctrl = wr_en_i && (wr_addr_i == OFS_CTRL);

  always_comb begin
    per_d  = per_q;
    duty_d = duty_q;
    ctrl_d = ctrl_q;
    if (we_per)  per_d  = wr_data_i;
    if (we_duty) duty_d = wr_data_i;
    if (we_ctrl) ctrl_d = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      duty_q <= '0;
      ctrl_q <= '0;
    end else begin
      per_q  <= per_d;
      duty_q <= duty_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign per_o         = per_q;
  assign duty_o        = duty_q;
  assign pol_o.duty_hi = ctrl_q[CB_DHI];
  assign pol_o.idle_hi = ctrl_q[CB_IHI];
  assign run_o         = ctrl_q[CB_EN] & ctrl_q[CB_CONT];
  assign lock_o        = ctrl_q[CB_LOCK];

  always_comb begin
    unique case (rd_addr_i)
      OFS_CNT:  rd_data_o = cnt_i;
      OFS_PER:  rd_data_o = per_q;
      OFS_DUTY: rd_data_o = duty_q;
      OFS_CTRL: rd_data_o = ctrl_q;
      default:  rd_data_o = '0;
    endcase
  end

  // R2: a period write is visible the next cycle
  p_readback_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && (wr_addr_i == OFS_PER)) |-> per_q == $past(wr_data_i));
endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
module pwm_counter
  import pwm_shadow_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          lock_i,
  input  logic [DW-1:0] per_shd_i,
  input  logic [DW-1:0] duty_shd_i,
  input  pwm_pol_t      pol_shd_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] per_o,
  output logic [DW-1:0] duty_o,
  output pwm_pol_t      pol_o
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] per_q, duty_q;
  pwm_pol_t      pol_q;
  logic          wrap, load;

  assign wrap = (per_q == '0) || (cnt_q == (per_q - ONE));
  assign load = !run_i || (wrap && !lock_i);

  always_comb begin
    if (!run_i || wrap) cnt_d = '0;
    else                cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      duty_q <= '0;
      pol_q  <= '0;
    end else if (load) begin
      per_q  <= per_shd_i;
      duty_q <= duty_shd_i;
      pol_q  <= pol_shd_i;
    end
  end

  assign cnt_o  = run_i ? cnt_q : '0;
  assign per_o  = per_q;
  assign duty_o = duty_q;
  assign pol_o  = pol_q;

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && per_q != '0) |-> cnt_q < per_q);

  p_idle_cnt_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> cnt_q == '0);

  p_locked_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && $past(lock_i)) |-> ($stable(per_q) && $stable(duty_q) && $stable(pol_q)));

  p_commit_at_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && (per_q != $past(per_q))) |-> cnt_q == '0);
endmodule

// File: rtl/pwm_outgen.sv
`timescale 1ns/1ps
module pwm_outgen
  import pwm_shadow_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          idle_live_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [DW-1:0] per_i,
  input  logic [DW-1:0] duty_i,
  input  pwm_pol_t      pol_i,
  output logic          pwm_o
);
  logic in_duty, level;

  assign in_duty = (per_i != '0) && (cnt_i < duty_i);
  assign level   = in_duty ? pol_i.duty_hi : pol_i.idle_hi;
  assign pwm_o   = run_i ? level : idle_live_i;

  p_full_duty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && per_i != '0 && duty_i >= per_i) |-> pwm_o == pol_i.duty_hi);
endmodule

// File: rtl/pwm_shadow_unit.sv
`timescale 1ns/1ps
module pwm_shadow_unit
  import pwm_shadow_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              pwm_o
);
  logic          rst_n;
  logic [DW-1:0] cnt, per_shd, duty_shd, per_act, duty_act;
  pwm_pol_t      pol_shd, pol_act;
  logic          run, lock;

  pwm_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n)
  );

  pwm_regbank #(.DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .cnt_i     (cnt),
    .per_o     (per_shd),
    .duty_o    (duty_shd),
    .pol_o     (pol_shd),
    .run_o     (run),
    .lock_o    (lock),
    .rd_data_o (rd_data_o)
  );

  pwm_counter #(.DW(DW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .run_i      (run),
    .lock_i     (lock),
    .per_shd_i  (per_shd),
    .duty_shd_i (duty_shd),
    .pol_shd_i  (pol_shd),
    .cnt_o      (cnt),
    .per_o      (per_act),
    .duty_o     (duty_act),
    .pol_o      (pol_act)
  );

  pwm_outgen #(.DW(DW)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .run_i       (run),
    .idle_live_i (pol_shd.idle_hi),
    .cnt_i       (cnt),
    .per_i       (per_act),
    .duty_i      (duty_act),
    .pol_i       (pol_act),
    .pwm_o       (pwm_o)
  );
endmodule

// File: tb/pwm_shadow_unit_tb_top.sv
`timescale 1ns/1ps
module pwm_shadow_unit_tb_top;
  localparam int DW = 32;
  localparam logic [31:0] C_EN = 32'h1, C_CONT = 32'h2, C_DHI = 32'h8,
                          C_IHI = 32'h10, C_LOCK = 32'h40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [3:0]    wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic          pwm;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pwm_shadow_unit #(.DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .pwm_o(pwm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [3:0] a, input logic [31:0] d);
    wr_en = we; wr_addr = a; wr_data = d;
  endtask

  function automatic logic [31:0] polbits(input logic [1:0] p);
    return (p[0] ? C_DHI : 32'h0) | (p[1] ? C_IHI : 32'h0);
  endfunction

  // mode 0: none, 1: lock/write/unlock, 2: unlocked writes, 3: lock never released
  task automatic run_case(input int p1, input int d1, input logic [1:0] q1,
                          input int p2, input int d2, input logic [1:0] q2,
                          input int mode, input int a, input int n, input string req);
    int u, s, p, d, idx;
    logic [1:0] q;
    logic [31:0] ecnt, epwm;
    @(negedge clk) drive(1, 4'hC, polbits(q1));
    @(negedge clk) drive(1, 4'h4, p1);
    @(negedge clk) drive(1, 4'h8, d1);
    @(negedge clk) drive(1, 4'hC, C_EN | C_CONT | polbits(q1));
    rd_addr = 4'h0;
    u = (mode == 1) ? a + 4 : (mode == 2) ? a + 3 : n + 1000;
    if (mode == 1 || mode == 2) s = (p1 == 0) ? u + 1 : ((u + p1) / p1) * p1;
    else s = n + 1000;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k < s) begin p = p1; d = d1; q = q1; idx = k; end
      else begin p = p2; d = d2; q = q2; idx = k - s; end
      ecnt = (p == 0) ? 0 : idx % p;
      epwm = (p != 0 && int'(ecnt) < d) ? {31'b0, q[0]} : {31'b0, q[1]};
      chk({req, " count"}, rd_data, ecnt);
      chk({req, " level"}, {31'b0, pwm}, epwm);
      drive(0, 4'h0, 0);
      if (mode == 1 || mode == 3) begin
        if (k == a)     drive(1, 4'hC, C_EN | C_CONT | C_LOCK | polbits(q1));
        if (k == a + 1) drive(1, 4'h4, p2);
        if (k == a + 2) drive(1, 4'h8, d2);
        if (k == a + 3 && mode == 1) drive(1, 4'hC, C_EN | C_CONT | polbits(q2));
      end else if (mode == 2) begin
        if (k == a)     drive(1, 4'h4, p2);
        if (k == a + 1) drive(1, 4'h8, d2);
        if (k == a + 2) drive(1, 4'hC, C_EN | C_CONT | polbits(q2));
      end
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 4'h0, 0);
    rd_addr = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 output", {31'b0, pwm}, 0);
    for (int i = 0; i < 4; i++) begin
      rd_addr = 4'(i * 4);
      #0.1 chk("R1 read", rd_data, 0);
    end

    // R3 R4 R5 R10: sweep of small periods, duties and polarity pairs
    for (int p = 0; p < 6; p++)
      for (int d = 0; d < 7; d++)
        for (int q = 0; q < 4; q++)
          run_case(p, d, 2'(q), p, d, 2'(q), 0, 0, 3 * p + 4, "R3/R4/R5/R10 sweep");

    // R7 R8: lock, write, unlock at several phases
    for (int a = 0; a < 5; a++)
      run_case(5, 2, 2'b00, 3, 3, 2'b10, 1, a, 30, "R8 locked commit");
    run_case(4, 1, 2'b01, 6, 5, 2'b10, 1, 7, 36, "R8 locked commit");
    run_case(3, 3, 2'b01, 0, 1, 2'b11, 1, 2, 20, "R5/R8 commit to zero period");
    run_case(4, 2, 2'b01, 2, 1, 2'b10, 3, 1, 30, "R7 lock held");
    // R9: unlocked writes wait for wrap
    run_case(5, 3, 2'b01, 2, 1, 2'b00, 2, 5, 24, "R9 staged");
    run_case(6, 0, 2'b10, 3, 3, 2'b01, 2, 1, 24, "R9 staged");

    // R6: enable qualification, disable behaviour
    run_case(4, 2, 2'b01, 4, 2, 2'b01, 0, 0, 3, "R6 prep");
    @(negedge clk) drive(1, 4'hC, C_CONT | C_IHI | C_DHI);
    @(negedge clk) drive(0, 4'h0, 0); rd_addr = 4'h0;
    #0.1 chk("R6 idle high", {31'b0, pwm}, 1);
    chk("R6 count cleared", rd_data, 0);
    @(negedge clk) drive(1, 4'hC, C_EN | C_DHI);
    repeat (3) @(negedge clk) begin
      drive(0, 4'h0, 0);
      chk("R6 enable only idle low", {31'b0, pwm}, 0);
      chk("R6 enable only count", rd_data, 0);
    end

    // R2: register map readback
    @(negedge clk) drive(1, 4'h4, 32'hDEAD_BEEF);
    @(negedge clk) drive(1, 4'h8, 32'h1234_5678);
    @(negedge clk) drive(1, 4'hC, 32'hA5A5_0150);
    @(negedge clk) drive(1, 4'h0, 32'hFFFF_FFFF);
    @(negedge clk) drive(1, 4'h6, 32'h7);
    @(negedge clk) drive(0, 4'h0, 0);
    rd_addr = 4'h4; #0.1 chk("R2 period", rd_data, 32'hDEAD_BEEF);
    rd_addr = 4'h8; #0.1 chk("R2 duty", rd_data, 32'h1234_5678);
    rd_addr = 4'hC; #0.1 chk("R2 control", rd_data, 32'hA5A5_0150);
    rd_addr = 4'h0; #0.1 chk("R2 counter read-only", rd_data, 0);
    rd_addr = 4'h6; #0.1 chk("R2 unmapped", rd_data, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule